// File: doc/BRIEF.md
# Octal Double-Data-Rate Serial Memory Target

This block sits on the device side of an eight-bit, double-data-rate serial memory link, in logic that takes the place of a flash chip. The host drives a chip select, a serial clock and eight data lines. The target samples the data lines on every serial clock edge, rising and falling. Each transaction has four phases: a two-byte command, a four-byte address, a latency wait counted in edges, and a data phase. In the data phase the target either stores incoming bytes in a 256-byte internal array, or drives bytes from that array together with a strobe that toggles once per byte.

The strobe pin also has a second use. From the moment the target is selected, it drives a level on the strobe that tells the host how long the latency will be. A high level asks for the doubled wait and a low level asks for the normal wait. The host reads this level a few clock cycles into the command phase. The latency operand and the doubled-latency request are inputs to the block, and the block latches them when it is selected. All link inputs pass through a synchronizer into the block's own clock domain. Serial clock edges are found by comparing the synchronized clock with its value on the previous cycle. The block's system clock must therefore run several times faster than the serial clock.

Top module: `octd_target`

## Requirements
- R1: During and just after reset, `dq_oe`, `ds_oe`, `ds_out` and `dq_out` are all zero.
- R2: From selection until the last address edge, `ds_oe` is 1 and `ds_out` equals the `lat_dbl` value latched at selection.
- R3: The command is two bytes taken on consecutive edges. 0x01 then 0x01 selects a write, and 0x02 then 0x02 selects a read. Any other pair releases the strobe. After that, the data bus is never driven and the array is never changed until deselection.
- R4: The address is four bytes taken on consecutive edges, most significant byte first. The low 8 bits of the address give the starting array index.
- R5: The latency wait, counted in edges after the last address edge, is `lat_op`*2-1 when the latched request is low, `lat_op`*4-1 when it is high, and 0 when `lat_op` is 0. During the wait the bus is released and the strobe is driven low.
- R6: On a read, the first byte appears on `dq_out` with `ds_out` high right after the last wait edge. If the wait is 0, it appears after the last address edge instead. Each later edge presents the next byte and toggles `ds_out`.
- R7: On a write, each edge after the wait stores the `dq_in` byte at the current index. Edges during the wait store nothing.
- R8: The index advances by one per data byte and wraps from 255 to 0.
- R9: `dq_oe` is high only in the read data phase.
- R10: When chip select goes high, the transaction ends in any phase. The block releases both `dq_oe` and `ds_oe` and returns to idle, and the next selection starts a new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from the host, active low |
| sclk | input | 1 | Serial clock from the host |
| dq_in | input | 8 | Data lines as seen from the pads |
| lat_op | input | OPW | Latency operand |
| lat_dbl | input | 1 | Doubled-latency request, shown on the strobe |
| dq_out | output | 8 | Read byte driven to the pads |
| dq_oe | output | 1 | Output enable for the data lines |
| ds_out | output | 1 | Strobe level |
| ds_oe | output | 1 | Output enable for the strobe |

## Verification
The assertions check the following on every cycle:
- the latency-request level on the strobe during the command and address phases;
- that a rejected command never writes the array;
- that the strobe toggles on every read edge and the index steps on every write edge;
- that the data bus is driven only in the read phase;
- that deselection releases both pins.

Other properties can only be shown by the bench's scenarios: the exact edge on which read data first appears for normal, doubled and zero latency, the address byte order, the wrap at the top of the array, and that bytes seen during the wait or after an aborted write do not reach the array. The bench shows them by reading the array back and comparing it with its own model.

// File: rtl/octd_pkg.sv
package octd_pkg;

    localparam logic [7:0] CMD_WR = 8'h01;
    localparam logic [7:0] CMD_RD = 8'h02;
    localparam int unsigned ADDR_BYTES = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_ADDR,
        S_LAT,
        S_RDATA,
        S_WDATA,
        S_SKIP
    } tgt_state_e;

endpackage

// File: rtl/octd_sync.sv
module octd_sync #(
    parameter int unsigned W = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[0] <= RST_VAL;
                    else        stg_q[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[i] <= RST_VAL;
                    else        stg_q[i] <= stg_q[i-1];
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/octd_lat_calc.sv
module octd_lat_calc #(
    parameter int unsigned OPW = 8,
    localparam int unsigned CW = OPW + 2
) (
    input  logic [OPW-1:0] op,
    input  logic           dbl,
    output logic [CW-1:0]  wait_edges
);
    always_comb begin
        if (op == '0)      wait_edges = '0;
        else if (dbl)      wait_edges = {op, 2'b00} - CW'(1);
        else               wait_edges = {1'b0, op, 1'b0} - CW'(1);
    end
endmodule

// File: rtl/octd_mem.sv
module octd_mem #(
    parameter int unsigned AW = 8,
    localparam int unsigned DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/octd_target.sv
module octd_target
    import octd_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter int unsigned OPW = 8,
    parameter int unsigned SYNC = 2,
    localparam int unsigned CW = OPW + 2,
    localparam int unsigned LW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           sclk,
    input  logic [7:0]     dq_in,
    input  logic [OPW-1:0] lat_op,
    input  logic           lat_dbl,
    output logic [7:0]     dq_out,
    output logic           dq_oe,
    output logic           ds_out,
    output logic           ds_oe
);
    typedef struct packed {
        tgt_state_e     st;
        logic           sck;
        logic [CW-1:0]  cnt;
        logic [7:0]     cmd0;
        logic           rd;
        logic [31:0]    addr;
        logic [AW-1:0]  idx;
        logic [OPW-1:0] op;
        logic           dbl;
        logic           dq_oe;
        logic           ds_o;
        logic           ds_oe;
    } regs_t;

    regs_t q, n;

    logic [LW-1:0] link_s;
    logic          cs_s, sck_s, edge_s, enter;
    logic [7:0]    din_s, mem_rd;
    logic [31:0]   a_nx;
    logic [CW-1:0] wait_e;
    logic          mem_we;

    octd_sync #(.W(LW), .STAGES(SYNC), .RST_VAL({1'b1, 1'b0, 8'h00})) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, dq_in}), .q(link_s)
    );
    assign cs_s   = link_s[9];
    assign sck_s  = link_s[8];
    assign din_s  = link_s[7:0];
    assign edge_s = sck_s ^ q.sck;

    octd_lat_calc #(.OPW(OPW)) u_lat (.op(q.op), .dbl(q.dbl), .wait_edges(wait_e));

    octd_mem #(.AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(q.idx), .wdata(din_s),
        .raddr(q.idx), .rdata(mem_rd)
    );

    always_comb begin
        n      = q;
        n.sck  = sck_s;
        mem_we = 1'b0;
        enter  = 1'b0;
        a_nx   = {q.addr[23:0], din_s};
        if (cs_s) begin
            n.st    = S_IDLE;
            n.dq_oe = 1'b0;
            n.ds_oe = 1'b0;
            n.ds_o  = 1'b0;
        end else begin
            case (q.st)
                S_IDLE: begin
                    n.st    = S_CMD;
                    n.cnt   = '0;
                    n.op    = lat_op;
                    n.dbl   = lat_dbl;
                    n.ds_oe = 1'b1;
                    n.ds_o  = lat_dbl;
                end
                S_CMD: if (edge_s) begin
                    if (q.cnt == '0) begin
                        n.cmd0 = din_s;
                        n.cnt  = CW'(1);
                    end else if (din_s == q.cmd0 && (din_s == CMD_WR || din_s == CMD_RD)) begin
                        n.st  = S_ADDR;
                        n.rd  = (din_s == CMD_RD);
                        n.cnt = '0;
                    end else begin
                        n.st    = S_SKIP;
                        n.ds_oe = 1'b0;
                        n.ds_o  = 1'b0;
                    end
                end
                S_ADDR: if (edge_s) begin
                    n.addr = a_nx;
                    n.cnt  = q.cnt + CW'(1);
                    if (q.cnt == CW'(ADDR_BYTES - 1)) begin
                        n.cnt  = '0;
                        n.idx  = a_nx[AW-1:0];
                        n.ds_o = 1'b0;
                        if (wait_e == '0) enter = 1'b1;
                        else              n.st  = S_LAT;
                    end
                end
                S_LAT: if (edge_s) begin
                    if (q.cnt + CW'(1) == wait_e) enter = 1'b1;
                    else                          n.cnt = q.cnt + CW'(1);
                end
                S_RDATA: if (edge_s) begin
                    n.idx  = q.idx + AW'(1);
                    n.ds_o = ~q.ds_o;
                end
                S_WDATA: if (edge_s) begin
                    mem_we = 1'b1;
                    n.idx  = q.idx + AW'(1);
                end
                default: ;
            endcase
            if (enter) begin
                if (q.rd) begin
                    n.st    = S_RDATA;
                    n.dq_oe = 1'b1;
                    n.ds_oe = 1'b1;
                    n.ds_o  = 1'b1;
                end else begin
                    n.st    = S_WDATA;
                    n.ds_oe = 1'b0;
                    n.ds_o  = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
        end else begin
            q <= n;
        end
    end

    assign dq_out = q.dq_oe ? mem_rd : 8'h00;
    assign dq_oe  = q.dq_oe;
    assign ds_out = q.ds_o;
    assign ds_oe  = q.ds_oe;

    // R2: latency request shown on the strobe through command and address
    a_r2_request_level: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_CMD || q.st == S_ADDR) |-> (ds_oe && ds_out == q.dbl));

    // R3: a rejected command never reaches the array
    a_r3_skip_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_SKIP) |-> !mem_we);

    // R6: every read edge toggles the strobe
    a_r6_strobe_step: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RDATA && edge_s && !cs_s) |=> (ds_out != $past(ds_out)));

    // R8: every write edge advances the index by one, wrapping
    a_r8_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WDATA && edge_s && !cs_s) |=> (q.idx == AW'($past(q.idx) + AW'(1))));

    // R9: data bus driven only in the read data phase
    a_r9_bus_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (q.st == S_RDATA));

    // R10: deselection releases both pins
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (!dq_oe && !ds_oe));
endmodule

// File: tb/sim_octd_target.sv
module sim_octd_target;
    localparam int H = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic [7:0] dq_in = 8'h00;
    logic [7:0] lat_op = 8'd0;
    logic       lat_dbl = 1'b0;
    logic [7:0] dq_out;
    logic       dq_oe, ds_out, ds_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [7:0] model [256];

    always #2 clk = ~clk;

    octd_target u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dq_in(dq_in),
        .lat_op(lat_op), .lat_dbl(lat_dbl), .dq_out(dq_out), .dq_oe(dq_oe),
        .ds_out(ds_out), .ds_oe(ds_oe)
    );

    // addr, op, dbl, bytes, seed
    localparam logic [63:0] VEC [6] = '{
        {32'h0000_0010, 8'd3, 8'd0, 8'd4, 8'h11},
        {32'h1234_5620, 8'd2, 8'd1, 8'd5, 8'h40},
        {32'h0000_00FE, 8'd1, 8'd0, 8'd4, 8'h80},
        {32'hFFFF_FF50, 8'd0, 8'd0, 8'd3, 8'hC3},
        {32'h0000_0070, 8'd8, 8'd1, 8'd2, 8'h05},
        {32'h0000_AA30, 8'd4, 8'd0, 8'd6, 8'h9A}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic [7:0] d);
        @(negedge clk);
        dq_in = d;
        sclk  = ~sclk;
        repeat (H) @(negedge clk);
    endtask

    task automatic deselect();
        @(negedge clk);
        cs_n = 1'b1;
        sclk = 1'b0;
        repeat (H) @(negedge clk);
        chk("R10", {dq_oe, ds_oe}, 2'b00);
    endtask

    function automatic int expw(input logic [7:0] op, input logic dbl);
        if (op == 0) return 0;
        return dbl ? op * 4 - 1 : op * 2 - 1;
    endfunction

    task automatic head(input logic [7:0] c0, input logic [7:0] c1,
                        input logic [7:0] op, input logic dbl);
        @(negedge clk);
        lat_op  = op;
        lat_dbl = dbl;
        cs_n    = 1'b0;
        repeat (H) @(negedge clk);
        lat_dbl = ~dbl;  // latched value must be kept
        chk("R2", {ds_oe, ds_out}, {1'b1, dbl});
        tick(c0);
        chk("R2", {ds_oe, ds_out}, {1'b1, dbl});
        tick(c1);
    endtask

    task automatic send_addr(input logic [31:0] a, input logic dbl);
        for (int k = 3; k >= 0; k--) begin
            if (k == 0) chk("R2", {ds_oe, ds_out}, {1'b1, dbl});
            tick(a[8*k +: 8]);
        end
    endtask

    task automatic do_write(input logic [31:0] a, input logic [7:0] op, input logic dbl,
                            input int nb, input logic [7:0] seed, input int stop_at);
        int w;
        logic [7:0] ix;
        w  = expw(op, dbl);
        ix = a[7:0];
        head(8'h01, 8'h01, op, dbl);
        send_addr(a, dbl);
        for (int e = 1; e <= w; e++) tick(8'hA5);  // R7: wait bytes ignored
        for (int k = 0; k < nb && k != stop_at; k++) begin
            tick(seed + 8'(k * 7));
            model[ix] = seed + 8'(k * 7);
            ix = ix + 8'd1;  // R8 wrap
            chk("R9", {31'd0, dq_oe}, 32'd0);
        end
        deselect();
    endtask

    task automatic do_read(input logic [31:0] a, input logic [7:0] op, input logic dbl,
                           input int nb, input int stop_at);
        int w;
        logic [7:0] ix;
        w  = expw(op, dbl);
        ix = a[7:0];
        head(8'h02, 8'h02, op, dbl);
        send_addr(a, dbl);
        if (w > 0) chk("R5", {dq_oe, ds_oe, ds_out}, 3'b010);
        for (int e = 1; e <= w; e++) begin
            tick(8'h00);
            if (e < w) chk("R5", {dq_oe, ds_out}, 2'b00);
        end
        for (int j = 0; j < nb && j != stop_at; j++) begin
            if (j > 0) tick(8'h00);
            chk("R6", {dq_oe, ds_out, dq_out}, {1'b1, ~j[0], model[ix]});
            ix = ix + 8'd1;
        end
        deselect();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1", {dq_oe, ds_oe, ds_out, dq_out}, 11'd0);
        rst_n = 1'b1;
        repeat (H) @(negedge clk);
        chk("R1", {dq_oe, ds_oe, ds_out, dq_out}, 11'd0);

        // R4 R5 R6 R7 R8: table of write then read-back with the other latency mode
        for (int v = 0; v < 6; v++) begin
            do_write(VEC[v][63:32], VEC[v][31:24], VEC[v][16], int'(VEC[v][15:8]), VEC[v][7:0], -1);
            do_read(VEC[v][63:32], VEC[v][31:24], ~VEC[v][16], int'(VEC[v][15:8]), -1);
        end

        // R3: unknown and mismatched commands
        head(8'h03, 8'h03, 8'd1, 1'b1);
        chk("R3", {ds_oe, dq_oe}, 2'b00);
        for (int k = 0; k < 10; k++) begin
            tick(8'hEE);
            chk("R3", {31'd0, dq_oe}, 32'd0);
        end
        deselect();
        head(8'h01, 8'h02, 8'd1, 1'b0);
        chk("R3", {ds_oe, dq_oe}, 2'b00);
        for (int k = 0; k < 8; k++) tick(8'h10);
        deselect();
        do_read(32'h0000_0010, 8'd1, 1'b0, 4, -1);

        // R10: write aborted after two bytes, remainder untouched
        do_write(32'h0000_0030, 8'd2, 1'b0, 6, 8'h61, 2);
        do_read(32'h0000_0030, 8'd2, 1'b0, 6, -1);

        // R10: read aborted mid data, then a clean read
        do_read(32'h0000_0020, 8'd3, 1'b1, 5, 2);
        do_read(32'h0000_0020, 8'd1, 1'b1, 5, -1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule